// File: doc/BRIEF.md
# Integration Window Controller

This block decides when a two-channel light-sensing converter integrates. Software programs one 8-bit control byte through a plain write/read port. A two-bit selector in that byte picks one of three preset window lengths, or hands the window to software. The preset lengths are counted in ticks from the on-chip oscillator, which arrive as a clock-enable pulse. In a preset mode the window runs all the time. Each time a period ends, the block raises a one-cycle done pulse and starts the next period.

In the software-timed mode, one bit of the byte opens the window when it is set and closes it when it is cleared. Closing an open window produces a done pulse. That bit has no effect in the preset modes. A gain bit passes straight through to the analog front end and serves both channels. Reserved bits are dropped on write.

The preset lengths are parameters. They should keep the ratios of roughly 0.034 : 0.252 : 1, and each must be at least 2 ticks.

Top module: `integ_window_ctrl`

## Requirements
- R1: After reset the control byte reads 0x02, `integ_o` is 1, `gain_hi_o` is 0, `done_o` is 0, and the long preset period counts from zero.
- R2: A write stores bits 4, 3, 1 and 0 of the data. Bits 7:5 and bit 2 always read back as 0.
- R3: `gain_hi_o` equals stored bit 4 (0 = 1x, 1 = 16x) in every mode.
- R4: With selector bits 1:0 = 00, 01 or 10, `done_o` is high in the cycle after the N-th tick of each period, where N is TICKS_SHORT, TICKS_MID or TICKS_LONG. Counting restarts at once, and `integ_o` stays 1.
- R5: Each `done_o` pulse lasts exactly one cycle.
- R6: A write that changes bits 1:0 aborts the current period, and counting restarts from zero under the new selector. This holds even if a tick that would have ended the period arrives in the same cycle; that period gives no pulse.
- R7: A write that leaves bits 1:0 unchanged does not disturb the count or a done pulse falling in the same cycle.
- R8: With bits 1:0 = 11, `integ_o` follows stored bit 3, and ticks never produce `done_o`.
- R9: With bits 1:0 = 11, a write of 11 with bit 3 cleared, made while bit 3 was set, raises `done_o` in the next cycle. Clearing bit 3 when it was already clear gives no pulse.
- R10: In the preset modes, bit 3 has no effect on `integ_o` or on pulse timing.
- R11: Entering mode 11 with bit 3 set opens the window at once. Leaving mode 11 with the window open gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control byte |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Stored control byte |
| tick_i | input | 1 | Oscillator tick, one cycle wide |
| integ_o | output | 1 | Integration window open |
| done_o | output | 1 | Period finished or manual window closed |
| gain_hi_o | output | 1 | High-gain select for both channels |

## Verification
Two events can land in the same cycle: a tick that ends a preset period, and a register write. Which one wins depends on whether the write changes the selector. The bench advances a short period to its last tick. It then issues the write together with that tick, once with a new selector and once with the same selector. In the first case it expects no pulse, then a full period of the new length counted from zero. In the second case it expects the pulse on time and the next period undisturbed.

// File: rtl/integ_pkg.sv
package integ_pkg;

  typedef enum logic [1:0] {
    SEL_SHORT  = 2'b00,
    SEL_MID    = 2'b01,
    SEL_LONG   = 2'b10,
    SEL_MANUAL = 2'b11
  } sel_e;

  localparam int unsigned CTRL_W     = 8;
  localparam int unsigned GAIN_BIT   = 4;
  localparam int unsigned MAN_BIT    = 3;
  localparam logic [CTRL_W-1:0] CTRL_RST   = 8'h02;
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'h1B;

endpackage

// File: rtl/integ_ctrl_reg.sv
module integ_ctrl_reg
  import integ_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output sel_e              sel_o,
  output logic              man_o,
  output logic              gain_o,
  output logic              sel_chg_o,
  output logic              man_stop_o
);

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= CTRL_RST;
    else if (wr_en_i) ctrl_q <= wr_data_i & CTRL_WMASK;
  end

  assign rd_data_o = ctrl_q;
  assign sel_o     = sel_e'(ctrl_q[1:0]);
  assign man_o     = ctrl_q[MAN_BIT];
  assign gain_o    = ctrl_q[GAIN_BIT];

  // window change requests decoded from the incoming write
  assign sel_chg_o  = wr_en_i && (wr_data_i[1:0] != ctrl_q[1:0]);
  assign man_stop_o = wr_en_i && (sel_o == SEL_MANUAL) && (wr_data_i[1:0] == SEL_MANUAL)
                      && ctrl_q[MAN_BIT] && !wr_data_i[MAN_BIT];

  assert_wr_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == ($past(wr_data_i) & CTRL_WMASK));

endmodule

// File: rtl/integ_period_cnt.sv
module integ_period_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last   = (cnt_q == lim_i - CNT_W'(1));
  assign wrap_o = run_i && tick_i && !clr_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || !run_i)  cnt_q <= '0;
    else if (tick_i)           cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
  end

  assert_cnt_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < lim_i);

  assert_abort_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/integ_window_ctrl.sv
module integ_window_ctrl
  import integ_pkg::*;
#(
  parameter int unsigned TICKS_SHORT = 13700,
  parameter int unsigned TICKS_MID   = 101000,
  parameter int unsigned TICKS_LONG  = 402000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  input  logic              tick_i,
  output logic              integ_o,
  output logic              done_o,
  output logic              gain_hi_o
);

  localparam int unsigned TICKS_MAX = (TICKS_LONG > TICKS_MID)
      ? ((TICKS_LONG > TICKS_SHORT) ? TICKS_LONG : TICKS_SHORT)
      : ((TICKS_MID > TICKS_SHORT) ? TICKS_MID : TICKS_SHORT);
  localparam int unsigned CNT_W = $clog2(TICKS_MAX + 1);
  localparam int unsigned N_PRESET = 3;
  localparam int unsigned PRESET_TICKS [N_PRESET] = '{TICKS_SHORT, TICKS_MID, TICKS_LONG};

  sel_e             sel;
  logic             man, sel_chg, man_stop, wrap, run;
  logic [CNT_W-1:0] lim_tab [N_PRESET];
  logic [CNT_W-1:0] lim;
  logic             done_q;

  integ_ctrl_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .sel_o      (sel),
    .man_o      (man),
    .gain_o     (gain_hi_o),
    .sel_chg_o  (sel_chg),
    .man_stop_o (man_stop)
  );

  for (genvar g = 0; g < N_PRESET; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'(PRESET_TICKS[g]);
  end

  always_comb begin
    unique case (sel)
      SEL_SHORT: lim = lim_tab[0];
      SEL_MID:   lim = lim_tab[1];
      default:   lim = lim_tab[2];
    endcase
  end

  assign run = (sel != SEL_MANUAL);

  integ_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (sel_chg),
    .run_i  (run),
    .lim_i  (lim),
    .wrap_o (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= wrap || man_stop;
  end

  assign done_o  = done_q;
  assign integ_o = run ? 1'b1 : man;

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_manual_no_tick_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_MANUAL && !wr_en_i) |=> !done_o);

  assert_manual_close_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sel == SEL_MANUAL) |-> !integ_o);

endmodule

// File: tb/test_integ_window_ctrl.sv
module test_integ_window_ctrl;

  localparam int unsigned T_S = 3;
  localparam int unsigned T_M = 21;
  localparam int unsigned T_L = 84;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       tick_i = 1'b0;
  logic       integ_o, done_o, gain_hi_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #10 clk_i = ~clk_i;

  integ_window_ctrl #(.TICKS_SHORT(T_S), .TICKS_MID(T_M), .TICKS_LONG(T_L)) i_integ_window_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o,
    .tick_i, .integ_o, .done_o, .gain_hi_o
  );

  function automatic int period_of(input int sel);
    return (sel == 0) ? T_S : (sel == 1) ? T_M : T_L;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle with optional tick; samples done 5 ns after the edge
  task automatic cyc(input logic t, output logic d);
    tick_i = t;
    @(posedge clk_i);
    #5;
    tick_i = 1'b0;
    d = done_o;
  endtask

  task automatic wr(input logic [7:0] v, input logic t, output logic d);
    wr_en_i = 1'b1;
    wr_data_i = v;
    tick_i = t;
    @(posedge clk_i);
    #5;
    wr_en_i = 1'b0;
    tick_i = 1'b0;
    d = done_o;
  endtask

  task automatic run_fixed(input int sel, input int gap, input int gain, input int man);
    logic d;
    logic [7:0] v;
    int n;
    n = period_of(sel);
    v = {3'b000, gain[0], man[0], 1'b0, sel[1:0]};
    wr(8'h03, 1'b0, d);
    wr(v, 1'b0, d);
    check("R10 integ in preset", int'(integ_o), 1);
    check("R3 gain", int'(gain_hi_o), gain);
    for (int i = 1; i <= 2 * n; i++) begin
      for (int g = 0; g < gap; g++) begin
        cyc(1'b0, d);
        check("R4 idle no done", int'(d), 0);
      end
      cyc(1'b1, d);
      check("R4 done at period end", int'(d), (i % n == 0) ? 1 : 0);
      if (i % n == 0) begin
        cyc(1'b0, d);
        check("R5 pulse width", int'(d), 0);
        check("R4 integ stays open", int'(integ_o), 1);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic d;
    #35;
    rst_ni = 1'b1;
    #2;
    // R1 reset state
    check("R1 reset byte", int'(rd_data_o), 8'h02);
    check("R1 integ", int'(integ_o), 1);
    check("R1 gain", int'(gain_hi_o), 0);
    check("R1 done", int'(done_o), 0);
    @(posedge clk_i);
    #5;
    for (int i = 1; i <= T_L; i++) begin
      cyc(1'b1, d);
      check("R1 long period from reset", int'(d), (i == T_L) ? 1 : 0);
    end

    // R2/R3 full byte sweep
    for (int v = 0; v < 256; v++) begin
      wr(8'(v), 1'b0, d);
      check("R2 readback", int'(rd_data_o), v & 8'h1B);
      check("R3 gain bit", int'(gain_hi_o), (v >> 4) & 1);
    end

    // R4/R10 preset sweep
    for (int sel = 0; sel < 3; sel++)
      for (int gap = 0; gap < 3; gap++)
        for (int gm = 0; gm < 4; gm++)
          run_fixed(sel, gap, gm >> 1, gm & 1);

    // R6 abort coinciding with terminal tick
    wr(8'h03, 1'b0, d);
    wr(8'h00, 1'b0, d);
    cyc(1'b1, d);
    cyc(1'b1, d);
    wr(8'h01, 1'b1, d);
    check("R6 abort suppresses done", int'(d), 0);
    for (int i = 1; i <= T_M; i++) begin
      cyc(1'b1, d);
      check("R6 new period from zero", int'(d), (i == T_M) ? 1 : 0);
    end

    // R7 same-selector write mid period and on terminal tick
    for (int i = 1; i < 10; i++) cyc(1'b1, d);
    wr(8'h11, 1'b1, d);
    check("R7 same sel write no done", int'(d), 0);
    check("R3 gain after write", int'(gain_hi_o), 1);
    for (int i = 11; i <= T_M; i++) begin
      cyc(1'b1, d);
      check("R7 count undisturbed", int'(d), (i == T_M) ? 1 : 0);
    end
    for (int i = 1; i < T_M; i++) cyc(1'b1, d);
    wr(8'h09, 1'b1, d);
    check("R7 done with same sel write", int'(d), 1);

    // R8/R9 manual mode
    wr(8'h03, 1'b0, d);
    check("R8 manual closed", int'(integ_o), 0);
    for (int i = 0; i < 100; i++) begin
      cyc(1'b1, d);
      if (d) check("R8 no tick done", int'(d), 0);
    end
    wr(8'h0B, 1'b0, d);
    check("R8 manual open", int'(integ_o), 1);
    check("R8 open no done", int'(d), 0);
    for (int i = 0; i < 100; i++) begin
      cyc(1'b1, d);
      if (d) check("R8 no tick done while open", int'(d), 0);
    end
    wr(8'h03, 1'b1, d);
    check("R9 stop done", int'(d), 1);
    check("R9 closed", int'(integ_o), 0);
    cyc(1'b0, d);
    check("R5 manual pulse width", int'(d), 0);
    wr(8'h03, 1'b0, d);
    check("R9 repeat stop no done", int'(d), 0);

    // R11 mode entry/exit
    wr(8'h0A, 1'b0, d);
    wr(8'h0B, 1'b0, d);
    check("R11 enter open", int'(integ_o), 1);
    check("R11 enter no done", int'(d), 0);
    wr(8'h02, 1'b0, d);
    check("R11 leave no done", int'(d), 0);
    check("R11 leave integ", int'(integ_o), 1);
    cyc(1'b0, d);
    check("R11 quiet after leave", int'(d), 0);

    ended = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule